// File: doc/BRIEF.md
# Character Font Line Packer

This block takes a stream of character font rows, each given as a legacy character code, a line number within the character and a 12-pixel row. It turns every row into the two byte writes that a linearly addressed character memory of 4096 twelve-bit words needs. On the way it moves the character sets from the legacy code layout to the compact layout. It also folds the line number and the relocated character code into a 12-bit word address. Upper-range characters use a rearranged set of line-number bits, so that ten lines of up to 384 characters fill the word space without collisions.

Each accepted row leaves the block as an even-address byte followed by an odd-address byte. The even byte carries the leftmost eight pixels, with the leftmost pixel in the most significant bit. The odd byte carries the last four pixels in its low nibble, and its upper nibble is zero. Each output byte is tagged with a flag that allows the shortened write pulse. The flag is set only on the even byte. Rows that fall into an unused or hardware-generated legacy range, and rows with a line number of ten or more, are consumed without output and counted. Both sides use a valid/ready handshake, and one row is taken every two output beats when the output never stalls.

Top module: `font_line_packer`

## Requirements
- R1: Legacy codes 0x020 to 0x0FF keep their code value after relocation.
- R2: Legacy codes 0x140..0x15F are relocated to 0x000..0x01F, and legacy codes 0x180..0x1FF are relocated to 0x100..0x17F (the code minus 0x080).
- R3: An input with legacy code in 0x000..0x01F, 0x100..0x13F or 0x160..0x17F, or with a line number of 10 or more, is accepted but produces no output byte. Each such input increments err_count by one, and err_count stops at its maximum value (255 by default).
- R4: For a relocated code n below 256 and line number L, the word address is L*256 + n.
- R5: For a relocated code n from 256 to 383 and line number L, the word address is formed from the bits, most significant first: 1, (L3 OR L2), NOT L2, L1, L0, n[6:0]. This gives 0xA00 + L*128 for L<4, 0xC00 + (L-4)*128 for L from 4 to 7, and 0xE00 + (L-8)*128 for L of 8 or 9, each plus n[6:0].
- R6: The first byte of each row has out_addr = 2*word, out_data = row[11:4] and out_short_pulse = 1.
- R7: The second byte follows the first directly. It has out_addr = 2*word+1, out_data = {4'b0000, row[3:0]} and out_short_pulse = 0.
- R8: While out_valid is high and out_ready is low, out_addr, out_data and out_short_pulse hold their values. in_ready is low while a first byte is waiting to be taken.
- R9: After reset, out_valid is 0, in_ready is 1 and err_count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input row valid |
| in_ready | output | 1 | Block can take a row |
| in_char | input | 9 | Legacy character code |
| in_line | input | 4 | Line number within the character |
| in_row | input | 12 | Pixel row, bit 11 is the leftmost pixel |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream takes the byte |
| out_addr | output | 13 | Byte address in the character memory |
| out_data | output | 8 | Byte value |
| out_short_pulse | output | 1 | Byte may be written with the shortened pulse |
| err_count | output | 8 | Saturating count of discarded rows |

## Verification
The assertions check on every cycle that output bytes stay stable under backpressure and that a first byte is always followed by its odd partner at the next address. They also check that the odd byte's upper nibble is zero, that upper-range characters land at word 0xA00 or above, and that the discard counter moves only on discarded rows and by exactly one. The actual set relocation, the exact scrambled address for each line number, the pixel placement and the saturation value can only be shown by the bench scenarios. In those scenarios a behavioural model predicts every byte from the requirements, under both free-flowing and randomly stalled output.

// File: rtl/font_pack_pkg.sv
package font_pack_pkg;

   // Splitter sequencing: nothing held, first byte pending, second byte pending
   typedef enum logic [1:0] {
      SPLIT_IDLE = 2'd0,
      SPLIT_HI   = 2'd1,
      SPLIT_LO   = 2'd2
   } split_state_t;

   // Legacy code windows that carry font data (9-bit legacy code space)
   localparam int unsigned KEEP_SAME_LO  = 'h020;
   localparam int unsigned KEEP_SAME_HI  = 'h0FF;
   localparam int unsigned SMALL_SET_LO  = 'h140;
   localparam int unsigned SMALL_SET_HI  = 'h15F;
   localparam int unsigned UPPER_SETS_LO = 'h180;
   localparam int unsigned UPPER_SETS_HI = 'h1FF;
   localparam int unsigned UPPER_SHIFT   = 'h080;

endpackage

// File: rtl/font_set_remap.sv
module font_set_remap
   import font_pack_pkg::*;
#(
   parameter int CHAR_W = 9
) (
   input  logic [CHAR_W-1:0] legacy_code,
   output logic [CHAR_W-1:0] new_code,
   output logic              code_kept
);

   localparam logic [CHAR_W-1:0] SAME_LO  = CHAR_W'(KEEP_SAME_LO);
   localparam logic [CHAR_W-1:0] SAME_HI  = CHAR_W'(KEEP_SAME_HI);
   localparam logic [CHAR_W-1:0] SMALL_LO = CHAR_W'(SMALL_SET_LO);
   localparam logic [CHAR_W-1:0] SMALL_HI = CHAR_W'(SMALL_SET_HI);
   localparam logic [CHAR_W-1:0] UP_LO    = CHAR_W'(UPPER_SETS_LO);
   localparam logic [CHAR_W-1:0] UP_HI    = CHAR_W'(UPPER_SETS_HI);
   localparam logic [CHAR_W-1:0] UP_SHIFT = CHAR_W'(UPPER_SHIFT);

   initial begin
      if (CHAR_W != 9)
         $error("font_set_remap: CHAR_W must be 9");
   end

   always_comb begin
      new_code  = '0;
      code_kept = 1'b0;
      if (legacy_code >= SAME_LO && legacy_code <= SAME_HI) begin
         new_code  = legacy_code;
         code_kept = 1'b1;
      end else if (legacy_code >= SMALL_LO && legacy_code <= SMALL_HI) begin
         new_code  = legacy_code - SMALL_LO;
         code_kept = 1'b1;
      end else if (legacy_code >= UP_LO && legacy_code <= UP_HI) begin
         new_code  = legacy_code - UP_SHIFT;
         code_kept = 1'b1;
      end
   end

endmodule

// File: rtl/font_line_scrambler.sv
module font_line_scrambler #(
   parameter int CHAR_W = 9,
   parameter int LINE_W = 4,
   parameter int WORD_W = 12
) (
   input  logic [CHAR_W-1:0] code,
   input  logic [LINE_W-1:0] line,
   output logic [WORD_W-1:0] word
);

   localparam int LOW_W = CHAR_W - 1;

   initial begin
      if (LINE_W != 4)
         $error("font_line_scrambler: LINE_W must be 4");
      if (WORD_W != LINE_W + LOW_W)
         $error("font_line_scrambler: WORD_W must equal LINE_W + CHAR_W - 1");
   end

   logic [WORD_W-1:0] word_lower;
   logic [WORD_W-1:0] word_upper;

   assign word_lower = {line, code[LOW_W-1:0]};
   assign word_upper = {1'b1, line[3] | line[2], ~line[2], line[1], line[0],
                        code[LOW_W-2:0]};

   assign word = code[CHAR_W-1] ? word_upper : word_lower;

endmodule

// File: rtl/font_byte_splitter.sv
module font_byte_splitter
   import font_pack_pkg::*;
#(
   parameter int ROW_W  = 12,
   parameter int BYTE_W = 8,
   parameter int WORD_W = 12,
   localparam int ADDR_W = WORD_W + 1,
   localparam int REST_W = ROW_W - BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_valid,
   output logic              ld_ready,
   input  logic [WORD_W-1:0] ld_word,
   input  logic [ROW_W-1:0]  ld_row,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [ADDR_W-1:0] out_addr,
   output logic [BYTE_W-1:0] out_data,
   output logic              out_short_pulse
);

   initial begin
      if (ROW_W <= BYTE_W || ROW_W > 2 * BYTE_W)
         $error("font_byte_splitter: ROW_W must lie in (BYTE_W, 2*BYTE_W]");
   end

   split_state_t      state_q, state_d;
   logic [WORD_W-1:0] word_q;
   logic [ROW_W-1:0]  row_q;
   logic              take;
   logic [BYTE_W-1:0] hi_byte;
   logic [BYTE_W-1:0] lo_byte;

   assign ld_ready = (state_q == SPLIT_IDLE) || (state_q == SPLIT_LO && out_ready);
   assign take     = ld_valid && ld_ready;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         SPLIT_IDLE: if (take) state_d = SPLIT_HI;
         SPLIT_HI:   if (out_ready) state_d = SPLIT_LO;
         SPLIT_LO:   if (out_ready) state_d = take ? SPLIT_HI : SPLIT_IDLE;
         default:    state_d = SPLIT_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SPLIT_IDLE;
         word_q  <= '0;
         row_q   <= '0;
      end else begin
         state_q <= state_d;
         if (take) begin
            word_q <= ld_word;
            row_q  <= ld_row;
         end
      end
   end

   assign hi_byte = row_q[ROW_W-1 -: BYTE_W];

   // Second byte: remaining pixels low, zero padding above them
   for (genvar gi = 0; gi < BYTE_W; gi++) begin : g_lo_bits
      if (gi < REST_W) begin : g_pix
         assign lo_byte[gi] = row_q[gi];
      end else begin : g_pad
         assign lo_byte[gi] = 1'b0;
      end
   end

   assign out_valid       = (state_q != SPLIT_IDLE);
   assign out_addr        = {word_q, state_q == SPLIT_LO};
   assign out_data        = (state_q == SPLIT_LO) ? lo_byte : hi_byte;
   assign out_short_pulse = (state_q == SPLIT_HI);

   // R8: byte held under backpressure
   p_hold_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_data)
                                  && $stable(out_short_pulse));

   // R7: a taken first byte is followed by its odd partner
   p_pair_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_ready && !out_addr[0] |=> out_valid && out_addr == $past(out_addr) + 1'b1
                                                  && !out_short_pulse);

   // R7: upper nibble of second byte is zero
   p_lo_pad_r7: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_addr[0] |-> out_data[BYTE_W-1:REST_W] == '0);

   // R8: no new row while the first byte still waits
   p_no_take_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_addr[0] |-> !ld_ready);

endmodule

// File: rtl/font_line_packer.sv
module font_line_packer #(
   parameter int CHAR_W        = 9,
   parameter int LINE_W        = 4,
   parameter int ROW_W         = 12,
   parameter int BYTE_W        = 8,
   parameter int LINES_PER_CHR = 10,
   parameter int ERR_W         = 8,
   parameter bit ERR_SATURATE  = 1'b1,
   localparam int WORD_W = LINE_W + CHAR_W - 1,
   localparam int ADDR_W = WORD_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [CHAR_W-1:0] in_char,
   input  logic [LINE_W-1:0] in_line,
   input  logic [ROW_W-1:0]  in_row,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [ADDR_W-1:0] out_addr,
   output logic [BYTE_W-1:0] out_data,
   output logic              out_short_pulse,
   output logic [ERR_W-1:0]  err_count
);

   localparam logic [LINE_W-1:0] LINE_LIMIT = LINE_W'(LINES_PER_CHR);
   localparam logic [ERR_W-1:0]  ERR_MAX    = '1;

   initial begin
      if (LINES_PER_CHR < 1 || LINES_PER_CHR > (1 << LINE_W))
         $error("font_line_packer: LINES_PER_CHR out of range for LINE_W");
      if (ERR_W < 1)
         $error("font_line_packer: ERR_W must be positive");
   end

   logic [CHAR_W-1:0] new_code;
   logic              code_kept;
   logic              row_kept;
   logic [WORD_W-1:0] word;
   logic              ld_ready;
   logic              drop_take;

   font_set_remap #(.CHAR_W(CHAR_W)) u_remap (
      .legacy_code (in_char),
      .new_code    (new_code),
      .code_kept   (code_kept)
   );

   font_line_scrambler #(.CHAR_W(CHAR_W), .LINE_W(LINE_W), .WORD_W(WORD_W)) u_scramble (
      .code (new_code),
      .line (in_line),
      .word (word)
   );

   assign row_kept  = code_kept && (in_line < LINE_LIMIT);
   assign in_ready  = ld_ready;
   assign drop_take = in_valid && in_ready && !row_kept;

   font_byte_splitter #(.ROW_W(ROW_W), .BYTE_W(BYTE_W), .WORD_W(WORD_W)) u_split (
      .clk             (clk),
      .rst_n           (rst_n),
      .ld_valid        (in_valid && row_kept),
      .ld_ready        (ld_ready),
      .ld_word         (word),
      .ld_row          (in_row),
      .out_valid       (out_valid),
      .out_ready       (out_ready),
      .out_addr        (out_addr),
      .out_data        (out_data),
      .out_short_pulse (out_short_pulse)
   );

   // Discard counter: saturating or wrapping variant
   if (ERR_SATURATE) begin : g_err_sat
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            err_count <= '0;
         else if (drop_take && err_count != ERR_MAX)
            err_count <= err_count + 1'b1;
      end

      // R3: counter moves by one per discarded row until full
      p_err_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
         drop_take && err_count != ERR_MAX |=> err_count == $past(err_count) + 1'b1);

      // R3: counter stays at its maximum
      p_err_sat_r3: assert property (@(posedge clk) disable iff (!rst_n)
         err_count == ERR_MAX |=> err_count == ERR_MAX);
   end else begin : g_err_wrap
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            err_count <= '0;
         else if (drop_take)
            err_count <= err_count + 1'b1;
      end
   end

   // R3: counter idle when nothing is discarded
   p_err_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !drop_take |=> $stable(err_count));

   // R3: a discarded row produces no new byte
   p_drop_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
      drop_take && !out_valid |=> !out_valid);

   // R5: upper-range codes land in the upper word region
   p_upper_region_r5: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready && row_kept && new_code[CHAR_W-1]
      |=> out_valid && out_addr[ADDR_W-1 -: 3] == 3'b101 || out_addr[ADDR_W-1 -: 2] == 2'b11);

endmodule

// File: tb/tb_font_line_packer.sv
module tb_font_line_packer;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [8:0]  in_char = '0;
   logic [3:0]  in_line = '0;
   logic [11:0] in_row = '0;
   logic        out_valid;
   logic        out_ready = 1'b0;
   logic [12:0] out_addr;
   logic [7:0]  out_data;
   logic        out_short_pulse;
   logic [7:0]  err_count;

   always #10 clk = ~clk;   // 50 MHz

   font_line_packer dut (
      .clk (clk), .rst_n (rst_n),
      .in_valid (in_valid), .in_ready (in_ready),
      .in_char (in_char), .in_line (in_line), .in_row (in_row),
      .out_valid (out_valid), .out_ready (out_ready),
      .out_addr (out_addr), .out_data (out_data),
      .out_short_pulse (out_short_pulse), .err_count (err_count)
   );

   int n_checks = 0;
   int n_fail   = 0;

   // stimulus queues
   int    s_chr[$];
   int    s_lin[$];
   int    s_row[$];
   string s_tag[$];
   // expected byte queues
   int    e_addr[$];
   int    e_data[$];
   int    e_short[$];
   string e_tag[$];
   int    model_err = 0;

   task automatic chk(input string tag, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic add(input int c, input int l, input int r, input string tag);
      s_chr.push_back(c); s_lin.push_back(l); s_row.push_back(r); s_tag.push_back(tag);
   endtask

   // behavioural model: relocation (R1 R2), -1 when discarded (R3)
   function automatic int relocate(input int c);
      if (c >= 'h020 && c <= 'h0FF) return c;
      if (c >= 'h140 && c <= 'h15F) return c - 'h140;
      if (c >= 'h180 && c <= 'h1FF) return c - 'h080;
      return -1;
   endfunction

   // word address (R4 R5)
   function automatic int word_of(input int n, input int l);
      if (n < 256) return l * 256 + n;
      if (l < 4)   return 'hA00 + l * 128 + (n % 128);
      if (l < 8)   return 'hC00 + (l - 4) * 128 + (n % 128);
      return 'hE00 + (l - 8) * 128 + (n % 128);
   endfunction

   task automatic model_accept(input int c, input int l, input int r, input string tag);
      int n;
      int w;
      n = relocate(c);
      if (n < 0 || l >= 10) begin
         if (model_err < 255) model_err++;
      end else begin
         w = word_of(n, l);
         e_addr.push_back(2 * w);     e_data.push_back(r / 16);
         e_short.push_back(1);        e_tag.push_back(tag);
         e_addr.push_back(2 * w + 1); e_data.push_back(r % 16);
         e_short.push_back(0);        e_tag.push_back(tag);
      end
   endtask

   int          rdy_mode = 0;
   logic [15:0] lfsr = 16'hACE1;
   logic        prev_stall = 1'b0;
   int          prev_addr, prev_data, prev_short;

   task automatic step();
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready = (rdy_mode == 0) ? 1'b1 : lfsr[0];
      if (s_chr.size() > 0 && (rdy_mode == 0 || lfsr[3])) begin
         in_valid = 1'b1;
         in_char  = 9'(s_chr[0]);
         in_line  = 4'(s_lin[0]);
         in_row   = 12'(s_row[0]);
      end else begin
         in_valid = 1'b0;
      end
      #1;
      // R8: held byte after stall
      if (prev_stall) begin
         chk("R8", "hold valid", int'(out_valid), 1);
         chk("R8", "hold addr", int'(out_addr), prev_addr);
         chk("R8", "hold data", int'(out_data), prev_data);
         chk("R8", "hold short", int'(out_short_pulse), prev_short);
      end
      prev_stall = out_valid && !out_ready;
      prev_addr = int'(out_addr); prev_data = int'(out_data); prev_short = int'(out_short_pulse);
      // R3: counter matches model each cycle
      chk("R3", "err_count", int'(err_count), model_err);
      if (out_valid) begin
         if (e_addr.size() == 0) begin
            chk("R3", "unexpected byte", int'(out_addr), -1);
         end else if (out_ready) begin
            // R6 (short=1) and R7 (short=0) compared byte by byte
            chk(e_tag[0], e_short[0] != 0 ? "R6 addr" : "R7 addr", int'(out_addr), e_addr[0]);
            chk(e_tag[0], e_short[0] != 0 ? "R6 data" : "R7 data", int'(out_data), e_data[0]);
            chk(e_tag[0], e_short[0] != 0 ? "R6 short" : "R7 short", int'(out_short_pulse), e_short[0]);
            void'(e_addr.pop_front()); void'(e_data.pop_front());
            void'(e_short.pop_front()); void'(e_tag.pop_front());
         end
      end
      if (in_valid && in_ready) begin
         model_accept(s_chr[0], s_lin[0], s_row[0], s_tag[0]);
         void'(s_chr.pop_front()); void'(s_lin.pop_front());
         void'(s_row.pop_front()); void'(s_tag.pop_front());
      end
   endtask

   task automatic drain();
      int guard = 0;
      while ((s_chr.size() > 0 || e_addr.size() > 0) && guard < 20000) begin
         step();
         guard++;
      end
      repeat (3) step();
      chk("R3", "queue drained", e_addr.size() + s_chr.size(), 0);
   endtask

   initial begin
      #(20 * 150000);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R9 reset state
      chk("R9", "out_valid", int'(out_valid), 0);
      chk("R9", "err_count", int'(err_count), 0);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk("R9", "in_ready", int'(in_ready), 1);
      chk("R9", "out_valid after release", int'(out_valid), 0);

      // R1 unchanged sets, R4 lower scramble
      add('h041, 0, 'hABC, "R1");
      add('h0FF, 9, 'hFFF, "R1");
      add('h020, 5, 'h001, "R4");
      add('h09A, 3, 'h5A5, "R4");
      // R2 relocation
      add('h140, 3, 'h123, "R2");
      add('h15F, 9, 'h800, "R2");
      // R5 upper scramble
      add('h180, 0, 'h3C7, "R5");
      add('h19F, 4, 'h0F0, "R5");
      add('h1A0, 8, 'hE1D, "R5");
      add('h1FF, 9, 'h7FF, "R5");
      for (int l = 0; l < 10; l++) add('h1B5, l, 'h100 + l * 17, "R5");
      // R3 discards
      add('h010, 2, 'hFFF, "R3");
      add('h100, 1, 'hFFF, "R3");
      add('h130, 0, 'hFFF, "R3");
      add('h170, 4, 'hFFF, "R3");
      add('h050, 10, 'hFFF, "R3");
      add('h1C0, 15, 'hFFF, "R3");
      add('h060, 7, 'h9B6, "R6");
      drain();

      // R8 random backpressure and input gaps
      rdy_mode = 1;
      for (int i = 0; i < 120; i++) begin
         int c;
         c = (i * 37 + 11) % 512;
         add(c, (i * 7) % 12, (i * 1237) % 4096, "R8");
      end
      drain();

      // R3 saturation
      rdy_mode = 0;
      for (int i = 0; i < 260; i++) add('h120 + (i % 16), i % 10, 0, "R3");
      add('h0A0, 1, 'hCAB, "R7");
      drain();
      chk("R3", "saturated count", int'(err_count), 255);

      $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

endmodule